// File: doc/BRIEF.md
# Hall-Sensor Commutation and PWM Gate Controller

This block drives the six switch enables of a three-phase half-bridge from three digitized Hall sensor bits. For each of the six valid rotor positions, one leg is pulled high, one is pulled low and the third floats. A direction input swaps the sequence by using the inverted Hall code. The high-side switch of the leg pulled high is chopped by a counter-based PWM. During the off-time of each chop, the low-side switch of that leg conducts instead of its body diode. The low-side switch of the leg pulled low conducts for the whole step.

A stop input removes the drive, and a brake-select input then chooses between shorting the three low sides or leaving every switch open. A fault input from the protection logic holds all high sides off. A current-sense comparator ends the present on-time, but only after a blanking window counted from the start of the PWM period. Once a trip is accepted, the high side stays off until the next period tick. Each leg passes through a dead-time stage, so one switch of a leg never turns on in fewer than `DEAD_CYCLES` clocks after the other switch of that leg turns off.

Top module: `hall_commutator`

## Requirements
- R1: Bit k of `hs_o`/`ls_o` drives leg k+1, and Hall sensor n is `hall_i[n-1]`. With `dir_rev_i`=0, the codes below are written as sensor 1,2,3 and give legs 1,2,3 as high (H), low (L) or floating (M): 101→L,H,M; 100→L,M,H; 110→M,L,H; 010→H,L,M; 011→H,M,L; 001→M,H,L. A leg in H has `hs_o`=1 and `ls_o`=0 while the chop is on. A leg in L has `ls_o`=1 only. A leg in M has both at 0.
- R2: With `dir_rev_i`=1, each Hall code produces the pattern that R1 gives for its bitwise complement. For example, 010 gives L,H,M.
- R3: `pwm_tick_i` starts a period. The high-side request of the H leg is asserted for the first `duty_i` clocks of the period. An all-ones `duty_i` means always on. The L leg's low side is not chopped.
- R4: While the H leg's high side is chopped off, that leg's low side is turned on after the dead time.
- R5: While `stop_i`=1, the Hall inputs are ignored. With `free_run_i`=0, all three low sides are on and all high sides are off. With `free_run_i`=1, all six switches are off. Outputs take the same values during reset as in free run.
- R6: A `ilim_trip_i` sample is ignored while the period counter is below `BLANK_CYCLES`. A trip accepted later turns the high side off one clock after it is sampled. The high side stays off until the next `pwm_tick_i`.
- R7: While `fault_i`=1, every high side is off one clock later.
- R8: Hall codes 000 and 111 turn all six switches off one clock later, when not stopped.
- R9: After a switch of a leg turns off, the other switch of that leg turns on no earlier than `DEAD_CYCLES` clocks later, with both off in between. Turn-offs take effect one clock after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hall_i | input | 3 | Digitized Hall bits, bit n-1 = sensor n |
| dir_rev_i | input | 1 | 1 selects reverse sequence |
| stop_i | input | 1 | 1 removes drive |
| free_run_i | input | 1 | Stop mode: 1 free run, 0 short brake |
| fault_i | input | 1 | Protection fault, forces high sides off |
| pwm_tick_i | input | 1 | PWM period start pulse |
| duty_i | input | DUTY_W | On-time in clocks, all ones = 100 % |
| ilim_trip_i | input | 1 | Current-limit comparator |
| hs_o | output | 3 | High-side enables, bit k = leg k+1 |
| ls_o | output | 3 | Low-side enables, bit k = leg k+1 |

## Verification
Any request that only turns switches off, or turns on a switch whose partner is already off and settled, is visible one clock after the inputs are sampled. A switch whose partner was on becomes visible `DEAD_CYCLES`+1 clocks after the request. PWM edges follow the period counter, which the tick clears on the edge that samples it. The high side therefore rises 5 clocks after the tick when a low-side handover is needed, falls `duty_i`+2 clocks after it, and falls 2 clocks after an accepted trip. Every expectation is queued with the exact clock in which it is due. A monitor compares it in the middle of that clock, away from the edge.

// File: rtl/hall_comm_pkg.sv
`timescale 1ns/1ps
package hall_comm_pkg;
  localparam int NUM_LEGS = 3;
  typedef enum logic [1:0] {
    LEG_OFF = 2'd0,
    LEG_HI  = 2'd1,
    LEG_LO  = 2'd2
  } leg_mode_e;
endpackage

// File: rtl/hall_comm_decode.sv
`timescale 1ns/1ps
module hall_comm_decode
  import hall_comm_pkg::*;
(
  input  logic [NUM_LEGS-1:0]            hall_i,
  input  logic                           dir_rev_i,
  output leg_mode_e [NUM_LEGS-1:0]       mode_o
);
  logic [2:0] h;
  logic [2:0] key; // sensor1, sensor2, sensor3

  always_comb begin
    h   = dir_rev_i ? ~hall_i : hall_i;
    key = {h[0], h[1], h[2]};
    mode_o = {NUM_LEGS{LEG_OFF}};
    unique case (key)
      3'b101: begin mode_o[0] = LEG_LO; mode_o[1] = LEG_HI; end
      3'b100: begin mode_o[0] = LEG_LO; mode_o[2] = LEG_HI; end
      3'b110: begin mode_o[1] = LEG_LO; mode_o[2] = LEG_HI; end
      3'b010: begin mode_o[0] = LEG_HI; mode_o[1] = LEG_LO; end
      3'b011: begin mode_o[0] = LEG_HI; mode_o[2] = LEG_LO; end
      3'b001: begin mode_o[1] = LEG_HI; mode_o[2] = LEG_LO; end
      default: mode_o = {NUM_LEGS{LEG_OFF}}; // 000 / 111
    endcase
  end
endmodule

// File: rtl/hall_pwm_chop.sv
`timescale 1ns/1ps
module hall_pwm_chop #(
  parameter int DUTY_W       = 8,
  parameter int BLANK_CYCLES = 60
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwm_tick_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic              ilim_trip_i,
  output logic              chop_o
);
  localparam logic [DUTY_W-1:0] BLANK = DUTY_W'(BLANK_CYCLES);

  logic [DUTY_W-1:0] cnt_q;
  logic              trip_q;
  logic              on_raw;
  logic              accept;

  assign on_raw = (&duty_i) | (cnt_q < duty_i);
  assign accept = ilim_trip_i & on_raw & (cnt_q >= BLANK);
  assign chop_o = on_raw & ~trip_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '1;
      trip_q <= 1'b0;
    end else if (pwm_tick_i) begin
      cnt_q  <= '0;
      trip_q <= 1'b0;
    end else begin
      if (~&cnt_q) cnt_q <= cnt_q + DUTY_W'(1);
      if (accept)  trip_q <= 1'b1;
    end
  end

  assert_blank_respected_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trip_q) |-> $past(cnt_q) >= BLANK);
  assert_trip_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_q && !pwm_tick_i |=> trip_q);
endmodule

// File: rtl/hall_leg_deadtime.sv
`timescale 1ns/1ps
module hall_leg_deadtime #(
  parameter int DEAD_CYCLES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hs_req_i,
  input  logic ls_req_i,
  output logic hs_o,
  output logic ls_o
);
  localparam int            CW   = (DEAD_CYCLES > 1) ? $clog2(DEAD_CYCLES) : 1;
  localparam logic [CW-1:0] LOAD = CW'(DEAD_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic hs_q, ls_q, hs_d, ls_d, clear, turn_off;

  assign clear    = (cnt_q == '0);
  assign hs_d     = hs_req_i & ~ls_req_i & (hs_q | (~ls_q & clear));
  assign ls_d     = ls_req_i & ~hs_req_i & (ls_q | (~hs_q & clear));
  assign turn_off = (hs_q & ~hs_d) | (ls_q & ~ls_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q  <= 1'b0;
      ls_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      hs_q <= hs_d;
      ls_q <= ls_d;
      if (turn_off)    cnt_q <= LOAD;
      else if (!clear) cnt_q <= cnt_q - CW'(1);
    end
  end

  assign hs_o = hs_q;
  assign ls_o = ls_q;

  assert_no_shoot_through_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_q && ls_q));
  assert_hs_after_gap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_q) |-> !$past(ls_q));
  assert_ls_after_gap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_q) |-> !$past(hs_q));
endmodule

// File: rtl/hall_commutator.sv
`timescale 1ns/1ps
module hall_commutator
  import hall_comm_pkg::*;
#(
  parameter int DUTY_W       = 8,
  parameter int BLANK_CYCLES = 60,
  parameter int DEAD_CYCLES  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        hall_i,
  input  logic              dir_rev_i,
  input  logic              stop_i,
  input  logic              free_run_i,
  input  logic              fault_i,
  input  logic              pwm_tick_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic              ilim_trip_i,
  output logic [2:0]        hs_o,
  output logic [2:0]        ls_o
);
  leg_mode_e [NUM_LEGS-1:0] mode;
  logic chop, chop_ok;

  hall_comm_decode u_decode (
    .hall_i    (hall_i),
    .dir_rev_i (dir_rev_i),
    .mode_o    (mode)
  );

  hall_pwm_chop #(.DUTY_W(DUTY_W), .BLANK_CYCLES(BLANK_CYCLES)) u_chop (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pwm_tick_i  (pwm_tick_i),
    .duty_i      (duty_i),
    .ilim_trip_i (ilim_trip_i),
    .chop_o      (chop)
  );

  assign chop_ok = chop & ~fault_i;

  for (genvar k = 0; k < NUM_LEGS; k++) begin : g_leg
    logic hs_req, ls_req;
    always_comb begin
      hs_req = 1'b0;
      ls_req = 1'b0;
      if (stop_i) begin
        ls_req = ~free_run_i;
      end else begin
        unique case (mode[k])
          LEG_HI: begin hs_req = chop_ok; ls_req = ~chop_ok; end // sync rectification
          LEG_LO: ls_req = 1'b1;
          default: ;
        endcase
      end
    end

    hall_leg_deadtime #(.DEAD_CYCLES(DEAD_CYCLES)) u_dead (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .hs_req_i (hs_req),
      .ls_req_i (ls_req),
      .hs_o     (hs_o[k]),
      .ls_o     (ls_o[k])
    );
  end

  assert_fault_hs_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |=> hs_o == '0);
  assert_brake_hs_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !free_run_i |=> hs_o == '0);
  assert_free_run_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && free_run_i |=> hs_o == '0 && ls_o == '0);
  assert_invalid_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stop_i && (hall_i == 3'b000 || hall_i == 3'b111) |=> hs_o == '0 && ls_o == '0);
endmodule

// File: tb/tb_hall_commutator.sv
`timescale 1ns/1ps
module tb_hall_commutator;
  localparam int DUTY_W = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst_ni;
  logic [2:0]        hall;
  logic              dir_rev, stop, free_run, fault, tick, trip;
  logic [DUTY_W-1:0] duty;
  logic [2:0]        hs_o, ls_o;

  hall_commutator #(.DUTY_W(DUTY_W), .BLANK_CYCLES(60), .DEAD_CYCLES(3)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .hall_i(hall), .dir_rev_i(dir_rev),
    .stop_i(stop), .free_run_i(free_run), .fault_i(fault),
    .pwm_tick_i(tick), .duty_i(duty), .ilim_trip_i(trip),
    .hs_o(hs_o), .ls_o(ls_o)
  );

  typedef struct {
    int         due;
    logic [2:0] hs;
    logic [2:0] ls;
    string      req;
  } exp_t;

  exp_t sb[$];
  int cyc = 0, n_chk = 0, n_fail = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare every expectation in the clock it is due
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due == cyc) begin
        n_chk++;
        if (hs_o !== sb[i].hs || ls_o !== sb[i].ls) begin
          n_fail++;
          $display("FAIL %s @%0d: hs=%b ls=%b expected hs=%b ls=%b",
                   sb[i].req, cyc, hs_o, ls_o, sb[i].hs, sb[i].ls);
        end
        sb.delete(i);
      end
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_at(int dly, logic [2:0] hs, logic [2:0] ls, string r);
    exp_t e;
    e.due = cyc + dly; e.hs = hs; e.ls = ls; e.req = r;
    sb.push_back(e);
  endtask

  // key written as sensor1,sensor2,sensor3
  function automatic logic [2:0] to_hall(logic [2:0] key);
    return {key[0], key[1], key[2]};
  endfunction

  // forward table from R1, bit k = leg k+1
  function automatic void fwd_exp(input logic [2:0] key, output logic [2:0] hs, output logic [2:0] ls);
    case (key)
      3'b101: begin hs = 3'b010; ls = 3'b001; end
      3'b100: begin hs = 3'b100; ls = 3'b001; end
      3'b110: begin hs = 3'b100; ls = 3'b010; end
      3'b010: begin hs = 3'b001; ls = 3'b010; end
      3'b011: begin hs = 3'b001; ls = 3'b100; end
      3'b001: begin hs = 3'b010; ls = 3'b100; end
      default: begin hs = 3'b000; ls = 3'b000; end
    endcase
  endfunction

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run incomplete at cycle %0d, expected completion", cyc);
      report();
      $finish;
    end
  end

  initial begin
    logic [2:0] rot [6] = '{3'b101, 3'b100, 3'b110, 3'b010, 3'b011, 3'b001};
    logic [2:0] ehs, els;
    rst_ni = 0; hall = 3'b000; dir_rev = 0; stop = 1; free_run = 0;
    fault = 0; tick = 0; trip = 0; duty = '1;
    step(1);
    expect_at(1, 3'b000, 3'b000, "reset");
    step(3);
    rst_ni = 1;
    expect_at(1, 3'b000, 3'b111, "R5 short brake");
    step(4);
    free_run = 1;
    expect_at(1, 3'b000, 3'b000, "R5 free run");
    step(4);

    // forward rotation, full duty
    stop = 0;
    foreach (rot[i]) begin
      hall = to_hall(rot[i]);
      fwd_exp(rot[i], ehs, els);
      expect_at(1, ehs, els, "R1 forward step");
      step(8);
    end

    // reverse
    dir_rev = 1;
    hall = to_hall(3'b010);
    expect_at(1, 3'b010, 3'b001, "R2 reverse 010");
    step(8);
    hall = to_hall(3'b101); // legs 1 and 2 swap sides
    expect_at(1, 3'b000, 3'b000, "R9 gap start");
    expect_at(3, 3'b000, 3'b000, "R9 gap held");
    expect_at(4, 3'b001, 3'b010, "R2 R9 reverse 101 after dead time");
    step(8);

    // invalid codes
    hall = to_hall(3'b000);
    expect_at(1, 3'b000, 3'b000, "R8 code 000");
    step(8);
    dir_rev = 0;
    hall = to_hall(3'b010);
    expect_at(1, 3'b001, 3'b010, "R1 forward 010");
    step(8);
    hall = to_hall(3'b111);
    expect_at(1, 3'b000, 3'b000, "R8 code 111");
    step(8);

    // fault
    hall = to_hall(3'b101);
    expect_at(1, 3'b010, 3'b001, "R1 forward 101");
    step(8);
    fault = 1;
    expect_at(1, 3'b000, 3'b001, "R7 high sides off");
    expect_at(4, 3'b000, 3'b011, "R7 R4 low side after dead time");
    step(8);
    fault = 0;
    expect_at(1, 3'b000, 3'b001, "R7 release");
    expect_at(4, 3'b010, 3'b001, "R7 high side back");
    step(8);

    // PWM duty
    duty = 8'd20;
    expect_at(1, 3'b000, 3'b001, "R3 no period, duty off");
    expect_at(4, 3'b000, 3'b011, "R4 recirculation");
    step(10);
    tick = 1;
    expect_at(5, 3'b010, 3'b001, "R3 on-time start");
    expect_at(21, 3'b010, 3'b001, "R3 on-time end");
    expect_at(22, 3'b000, 3'b001, "R3 off-time");
    expect_at(25, 3'b000, 3'b011, "R4 sync rectification");
    step(1);
    tick = 0;
    step(40);

    // blanking and trip
    duty = 8'd100;
    tick = 1;
    expect_at(5, 3'b010, 3'b001, "R3 period start");
    expect_at(20, 3'b010, 3'b001, "R6 trip in blank ignored");
    expect_at(71, 3'b010, 3'b001, "R6 trip sampled");
    expect_at(72, 3'b000, 3'b001, "R6 trip cuts on-time");
    expect_at(75, 3'b000, 3'b011, "R6 R4 low side after trip");
    expect_at(90, 3'b000, 3'b011, "R6 held until period end");
    step(1);
    tick = 0;
    step(9);
    trip = 1;
    step(1);
    trip = 0;
    step(59);
    trip = 1;
    step(1);
    trip = 0;
    step(60);
    tick = 1;
    expect_at(5, 3'b010, 3'b001, "R6 new period clears trip");
    step(1);
    tick = 0;
    step(10);

    // stop with brake, hall ignored
    duty = '1;
    stop = 1; free_run = 0;
    expect_at(1, 3'b000, 3'b101, "R5 brake entry");
    expect_at(4, 3'b000, 3'b111, "R5 brake full");
    step(6);
    hall = to_hall(3'b011);
    expect_at(2, 3'b000, 3'b111, "R5 hall ignored while stopped");
    step(4);
    free_run = 1;
    expect_at(1, 3'b000, 3'b000, "R5 free run");
    step(4);

    while (sb.size() != 0) step(1);
    step(2);
    done = 1;
    report();
    $finish;
  end
endmodule